// File: doc/BRIEF.md
# Reorder-Buffer Rename Unit with Committed Register File

This block renames the registers of decoded instructions for an out-of-order core. Committed state sits in a 16-entry architectural register file. Results that are still speculative are held only in reorder-buffer entries. There is no physical register pool and no free list.

Each accepted instruction names one destination and two sources. It receives the reorder-buffer slot at the tail. One cycle later, the block reports each source either as a ready operand value or as the slot id of its producer. Execution results return by slot id. The oldest slot retires into the register file as soon as its result is present. A flush discards every speculative slot and points all registers back at the committed file.

The block sits between decode and the instruction window. The window captures operand values from the rename output and later matches write-back slot ids against its waiting tags.

Top module: `rob_rename`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` and `cm_valid` are 0, and every register reads as ready with value 0 and tag 0.
- R2: Accepted instructions (`in_valid` and `in_ready`) receive consecutive slot ids modulo 16, starting at 0. The result appears on `out_*` with `out_valid` in the following cycle.
- R3: With 16 slots in flight, `in_ready` is 0 and `in_valid` is ignored: no slot is taken and `out_valid` stays 0.
- R4: A source mapped to the committed file is reported ready, with the file's value and tag 0.
- R5: A source mapped to an in-flight slot whose result is present is reported ready, with that slot's value and the slot id as tag.
- R6: A source mapped to an in-flight slot without a result is reported not ready, with the slot id as tag.
- R7: A write-back to the very slot a lookup names, in the lookup's cycle, is forwarded: the source is reported ready with the written value.
- R8: Sources are looked up before the instruction's own destination mapping is installed. A source equal to the destination therefore sees the older producer.
- R9: A write-back marks its in-flight slot ready and stores the value. A repeated write-back to that slot replaces the value.
- R10: The oldest slot retires once its result is present, at most one per cycle and strictly in slot order. The following cycle shows `cm_valid` with the slot id, destination and value, and the value is written into the committed file.
- R11: At retirement, the destination reverts to the committed file only if it still maps to the retiring slot and is not being remapped in the same cycle.
- R12: While `flush` is high, nothing is accepted, written back or retired. Afterwards the buffer is empty, every register maps to the committed file, and the next slot id is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_dst | input | 4 | Destination register |
| in_src0 | input | 4 | First source register |
| in_src1 | input | 4 | Second source register |
| in_ready | output | 1 | A slot is free |
| wb_valid | input | 1 | Execution result offered |
| wb_id | input | 4 | Slot id of the producer |
| wb_data | input | 32 | Result value |
| flush | input | 1 | Discard all speculative state |
| out_valid | output | 1 | Rename result valid |
| out_id | output | 4 | Slot given to the instruction |
| out_s0_rdy | output | 1 | First source value present |
| out_s0_val | output | 32 | First source value |
| out_s0_tag | output | 4 | First source producer slot (0 when committed) |
| out_s1_rdy | output | 1 | Second source value present |
| out_s1_val | output | 32 | Second source value |
| out_s1_tag | output | 4 | Second source producer slot (0 when committed) |
| cm_valid | output | 1 | A slot retired |
| cm_id | output | 4 | Retired slot |
| cm_dst | output | 4 | Retired destination |
| cm_data | output | 32 | Retired value |

## Verification
Two pairs of operations can land in the same cycle. The first pair is a write-back and a rename lookup of that same slot, where the value must be forwarded. The second pair is a retirement and an allocation that targets the retiring destination, where the new mapping must survive. A directed sequence forces the forwarding case right after reset and a retirement in the next cycle. Long random traffic then mixes writes to live, stale and repeated slots with occasional flushes. Every rename and retirement output is compared against a bench model that applies a cycle's lookups before that cycle's updates.

// File: rtl/rob_rename_pkg.sv
package rob_rename_pkg;
  localparam int unsigned RR_NREG   = 16;
  localparam int unsigned RR_DEPTH  = 16;
  localparam int unsigned RR_DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_ARCH,
    SRC_ROB,
    SRC_FWD,
    SRC_WAIT
  } src_kind_e;
endpackage

// File: rtl/rr_src_lookup.sv
module rr_src_lookup #(
  parameter int IW = 4,
  parameter int DW = 32
) (
  input  logic          loc,
  input  logic [IW-1:0] id,
  input  logic [DW-1:0] arch_data,
  input  logic          ent_ready,
  input  logic [DW-1:0] ent_data,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_id,
  input  logic [DW-1:0] wb_data,
  output logic          rdy,
  output logic [DW-1:0] val,
  output logic [IW-1:0] tag
);
  import rob_rename_pkg::*;

  src_kind_e kind;

  always_comb begin
    if (!loc)                          kind = SRC_ARCH;
    else if (ent_ready)                kind = SRC_ROB;
    else if (wb_en && (wb_id == id))   kind = SRC_FWD;
    else                               kind = SRC_WAIT;
    rdy = (kind != SRC_WAIT);
    tag = loc ? id : '0;
    unique case (kind)
      SRC_ARCH: val = arch_data;
      SRC_ROB:  val = ent_data;
      SRC_FWD:  val = wb_data;
      default:  val = '0;
    endcase
  end
endmodule

// File: rtl/rr_map_table.sv
module rr_map_table #(
  parameter int NREG = 16,
  parameter int AW   = 4,
  parameter int IW   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [1:0][AW-1:0]  rd_addr,
  output logic [1:0]          rd_loc,
  output logic [1:0][IW-1:0]  rd_id,
  input  logic                set_en,
  input  logic [AW-1:0]       set_reg,
  input  logic [IW-1:0]       set_id,
  input  logic                clr_en,
  input  logic [AW-1:0]       clr_reg,
  input  logic [IW-1:0]       clr_id
);
  logic [NREG-1:0] loc_q;
  logic [IW-1:0]   id_q [NREG];
  logic            clr_hit;

  assign clr_hit = clr_en && loc_q[clr_reg] && (id_q[clr_reg] == clr_id) &&
                   !(set_en && (set_reg == clr_reg));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      loc_q <= '0;
    end else begin
      if (clr_hit) loc_q[clr_reg] <= 1'b0;
      if (set_en)  loc_q[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) id_q[set_reg] <= set_id;
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    assign rd_loc[g] = loc_q[rd_addr[g]];
    assign rd_id[g]  = id_q[rd_addr[g]];
  end
endmodule

// File: rtl/rr_arch_file.sv
module rr_arch_file #(
  parameter int NREG = 16,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [1:0][AW-1:0] raddr,
  output logic [1:0][DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/rr_rob_store.sv
module rr_rob_store #(
  parameter int DEPTH = 16,
  parameter int IW    = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               alloc_en,
  input  logic [AW-1:0]      alloc_dst,
  output logic [IW-1:0]      alloc_id,
  output logic               full,
  input  logic               wb_en,
  input  logic [IW-1:0]      wb_id,
  input  logic [DW-1:0]      wb_data,
  input  logic [1:0][IW-1:0] rd_id,
  output logic [1:0]         rd_ready,
  output logic [1:0][DW-1:0] rd_data,
  output logic               head_ok,
  output logic [IW-1:0]      head_id,
  output logic [AW-1:0]      head_dst,
  output logic [DW-1:0]      head_data,
  input  logic               commit_en
);
  logic [IW-1:0]    head_q, tail_q;
  logic [IW:0]      cnt_q;
  logic [DEPTH-1:0] vld_q, rdy_q;
  logic [AW-1:0]    dst_mem  [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic             wb_hit;

  assign wb_hit    = wb_en && vld_q[wb_id];
  assign full      = (cnt_q == (IW+1)'(DEPTH));
  assign alloc_id  = tail_q;
  assign head_id   = head_q;
  assign head_ok   = (cnt_q != '0) && rdy_q[head_q];
  assign head_dst  = dst_mem[head_q];
  assign head_data = data_mem[head_q];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (commit_en) head_q <= head_q + IW'(1);
      if (alloc_en)  tail_q <= tail_q + IW'(1);
      cnt_q <= cnt_q + (IW+1)'(alloc_en) - (IW+1)'(commit_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      if (commit_en) vld_q[head_q] <= 1'b0;
      if (wb_hit)    rdy_q[wb_id]  <= 1'b1;
      if (alloc_en) begin
        vld_q[tail_q] <= 1'b1;
        rdy_q[tail_q] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wb_hit)   data_mem[wb_id] <= wb_data;
    if (alloc_en) dst_mem[tail_q] <= alloc_dst;
  end

  for (genvar g = 0; g < 2; g++) begin : g_rd
    assign rd_ready[g] = rdy_q[rd_id[g]];
    assign rd_data[g]  = data_mem[rd_id[g]];
  end
endmodule

// File: rtl/rob_rename.sv
module rob_rename #(
  parameter int NREG  = rob_rename_pkg::RR_NREG,
  parameter int DEPTH = rob_rename_pkg::RR_DEPTH,
  parameter int DW    = rob_rename_pkg::RR_DATA_W,
  localparam int AW   = $clog2(NREG),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_src0,
  input  logic [AW-1:0] in_src1,
  output logic          in_ready,
  input  logic          wb_valid,
  input  logic [IW-1:0] wb_id,
  input  logic [DW-1:0] wb_data,
  input  logic          flush,
  output logic          out_valid,
  output logic [IW-1:0] out_id,
  output logic          out_s0_rdy,
  output logic [DW-1:0] out_s0_val,
  output logic [IW-1:0] out_s0_tag,
  output logic          out_s1_rdy,
  output logic [DW-1:0] out_s1_val,
  output logic [IW-1:0] out_s1_tag,
  output logic          cm_valid,
  output logic [IW-1:0] cm_id,
  output logic [AW-1:0] cm_dst,
  output logic [DW-1:0] cm_data
);
  logic               full, accept, wb_en, commit_en, head_ok;
  logic [IW-1:0]      alloc_id, head_id;
  logic [AW-1:0]      head_dst;
  logic [DW-1:0]      head_data;
  logic [1:0][AW-1:0] src_addr;
  logic [1:0]         map_loc, ent_rdy, src_rdy;
  logic [1:0][IW-1:0] map_id, src_tag;
  logic [1:0][DW-1:0] arch_val, ent_val, src_val;

  assign in_ready  = !full;
  assign accept    = in_valid && !full && !flush;
  assign wb_en     = wb_valid && !flush;
  assign commit_en = head_ok && !flush;
  assign src_addr  = {in_src1, in_src0};

  rr_map_table #(.NREG(NREG), .AW(AW), .IW(IW)) u_map (
    .clk(clk), .rst(rst), .flush(flush),
    .rd_addr(src_addr), .rd_loc(map_loc), .rd_id(map_id),
    .set_en(accept), .set_reg(in_dst), .set_id(alloc_id),
    .clr_en(commit_en), .clr_reg(head_dst), .clr_id(head_id)
  );

  rr_arch_file #(.NREG(NREG), .AW(AW), .DW(DW)) u_arf (
    .clk(clk), .rst(rst), .we(commit_en), .waddr(head_dst), .wdata(head_data),
    .raddr(src_addr), .rdata(arch_val)
  );

  rr_rob_store #(.DEPTH(DEPTH), .IW(IW), .AW(AW), .DW(DW)) u_rob (
    .clk(clk), .rst(rst), .flush(flush),
    .alloc_en(accept), .alloc_dst(in_dst), .alloc_id(alloc_id), .full(full),
    .wb_en(wb_en), .wb_id(wb_id), .wb_data(wb_data),
    .rd_id(map_id), .rd_ready(ent_rdy), .rd_data(ent_val),
    .head_ok(head_ok), .head_id(head_id), .head_dst(head_dst),
    .head_data(head_data), .commit_en(commit_en)
  );

  for (genvar g = 0; g < 2; g++) begin : g_src
    rr_src_lookup #(.IW(IW), .DW(DW)) u_lk (
      .loc(map_loc[g]), .id(map_id[g]), .arch_data(arch_val[g]),
      .ent_ready(ent_rdy[g]), .ent_data(ent_val[g]),
      .wb_en(wb_en), .wb_id(wb_id), .wb_data(wb_data),
      .rdy(src_rdy[g]), .val(src_val[g]), .tag(src_tag[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_id     <= '0;
      out_s0_rdy <= 1'b0;
      out_s0_val <= '0;
      out_s0_tag <= '0;
      out_s1_rdy <= 1'b0;
      out_s1_val <= '0;
      out_s1_tag <= '0;
      cm_valid   <= 1'b0;
      cm_id      <= '0;
      cm_dst     <= '0;
      cm_data    <= '0;
    end else begin
      out_valid  <= accept;
      out_id     <= alloc_id;
      out_s0_rdy <= src_rdy[0];
      out_s0_val <= src_val[0];
      out_s0_tag <= src_tag[0];
      out_s1_rdy <= src_rdy[1];
      out_s1_val <= src_val[1];
      out_s1_tag <= src_tag[1];
      cm_valid   <= commit_en;
      cm_id      <= head_id;
      cm_dst     <= head_dst;
      cm_data    <= head_data;
    end
  end
endmodule

// File: rtl/rob_rename_checker.sv
module rob_rename_checker #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          in_ready,
  input logic          out_valid,
  input logic [IW-1:0] out_id,
  input logic          cm_valid,
  input logic [IW-1:0] cm_id
);
  logic [IW-1:0] exp_tail, exp_head;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      exp_tail <= '0;
      exp_head <= '0;
    end else begin
      if (out_valid) exp_tail <= exp_tail + IW'(1);
      if (cm_valid)  exp_head <= exp_head + IW'(1);
    end
  end

  assert_alloc_order_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_id == exp_tail));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !out_valid);

  assert_commit_order_R10: assert property (@(posedge clk) disable iff (rst)
    cm_valid |-> (cm_id == exp_head));

  assert_flush_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !cm_valid && in_ready));
endmodule

bind rob_rename rob_rename_checker #(.IW(IW)) u_check (
  .clk(clk), .rst(rst), .flush(flush), .in_ready(in_ready),
  .out_valid(out_valid), .out_id(out_id), .cm_valid(cm_valid), .cm_id(cm_id)
);

// File: tb/rob_rename_test.sv
module rob_rename_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, wb_valid = 1'b0, flush = 1'b0;
  logic [3:0]  in_dst = '0, in_src0 = '0, in_src1 = '0, wb_id = '0;
  logic [31:0] wb_data = '0;
  logic        in_ready, out_valid, out_s0_rdy, out_s1_rdy, cm_valid;
  logic [3:0]  out_id, out_s0_tag, out_s1_tag, cm_id, cm_dst;
  logic [31:0] out_s0_val, out_s1_val, cm_data;

  always #5 clk = ~clk;

  rob_rename uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dst(in_dst),
    .in_src0(in_src0), .in_src1(in_src1), .in_ready(in_ready),
    .wb_valid(wb_valid), .wb_id(wb_id), .wb_data(wb_data), .flush(flush),
    .out_valid(out_valid), .out_id(out_id),
    .out_s0_rdy(out_s0_rdy), .out_s0_val(out_s0_val), .out_s0_tag(out_s0_tag),
    .out_s1_rdy(out_s1_rdy), .out_s1_val(out_s1_val), .out_s1_tag(out_s1_tag),
    .cm_valid(cm_valid), .cm_id(cm_id), .cm_dst(cm_dst), .cm_data(cm_data)
  );

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [31:0] m_arf [16];
  bit          m_loc [16];
  int          m_map [16];
  string       m_org [16];
  bit          m_v [16], m_r [16];
  int          m_dst [16];
  logic [31:0] m_val [16];
  int          m_head, m_tail, m_cnt;

  // expectations for the next sample
  bit          e_ov, e_cv, e_fl;
  int          e_oid, e_cid, e_cdst;
  bit          e_rdy [2];
  logic [31:0] e_val [2];
  int          e_tag [2];
  string       e_lab [2];
  logic [31:0] e_cdata;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic void model_reset(input string org);
    for (int i = 0; i < 16; i++) begin
      m_loc[i] = 0; m_org[i] = org; m_v[i] = 0; m_r[i] = 0;
    end
    m_head = 0; m_tail = 0; m_cnt = 0;
  endfunction

  task automatic check_outputs();
    string lab_v, lab_c;
    lab_v = e_fl ? "R12" : "R2";
    lab_c = e_fl ? "R12" : "R10";
    chk("R3 in_ready", {31'b0, in_ready}, {31'b0, m_cnt < 16});
    chk({lab_v, " out_valid"}, {31'b0, out_valid}, {31'b0, e_ov});
    if (e_ov) begin
      chk("R2 out_id", {28'b0, out_id}, e_oid);
      chk({e_lab[0], " s0 rdy"}, {31'b0, out_s0_rdy}, {31'b0, e_rdy[0]});
      chk({e_lab[0], " s0 tag"}, {28'b0, out_s0_tag}, e_tag[0]);
      if (e_rdy[0]) chk({e_lab[0], " s0 val"}, out_s0_val, e_val[0]);
      chk({e_lab[1], " s1 rdy"}, {31'b0, out_s1_rdy}, {31'b0, e_rdy[1]});
      chk({e_lab[1], " s1 tag"}, {28'b0, out_s1_tag}, e_tag[1]);
      if (e_rdy[1]) chk({e_lab[1], " s1 val"}, out_s1_val, e_val[1]);
    end
    chk({lab_c, " cm_valid"}, {31'b0, cm_valid}, {31'b0, e_cv});
    if (e_cv) begin
      chk("R10 cm_id", {28'b0, cm_id}, e_cid);
      chk("R10 cm_dst", {28'b0, cm_dst}, e_cdst);
      chk("R9 cm_data", cm_data, e_cdata);
    end
  endtask

  task automatic step(input bit iv, input int dst, input int s0, input int s1,
                      input bit wv, input int wid, input logic [31:0] wd, input bit fl);
    int src [2];
    bit acc, cm;
    @(negedge clk);
    check_outputs();
    in_valid = iv; in_dst = 4'(dst); in_src0 = 4'(s0); in_src1 = 4'(s1);
    wb_valid = wv; wb_id = 4'(wid); wb_data = wd; flush = fl;
    e_fl = fl;
    if (fl) begin
      model_reset("R12");
      e_ov = 0; e_cv = 0;
      return;
    end
    acc = iv && (m_cnt < 16);
    cm  = (m_cnt > 0) && m_r[m_head];
    e_ov = acc; e_oid = m_tail;
    src[0] = s0; src[1] = s1;
    for (int g = 0; g < 2; g++) begin
      int s, id;
      s = src[g];
      if (!m_loc[s]) begin
        e_rdy[g] = 1; e_val[g] = m_arf[s]; e_tag[g] = 0; e_lab[g] = m_org[s];
      end else begin
        id = m_map[s]; e_tag[g] = id;
        if (m_r[id]) begin
          e_rdy[g] = 1; e_val[g] = m_val[id]; e_lab[g] = "R5";
        end else if (wv && wid == id) begin
          e_rdy[g] = 1; e_val[g] = wd; e_lab[g] = "R7";
        end else begin
          e_rdy[g] = 0; e_val[g] = '0; e_lab[g] = "R6";
        end
      end
      if (s == dst) e_lab[g] = "R8";
    end
    e_cv = cm;
    if (cm) begin
      e_cid = m_head; e_cdst = m_dst[m_head]; e_cdata = m_val[m_head];
    end
    if (wv && m_v[wid]) begin
      m_r[wid] = 1; m_val[wid] = wd;
    end
    if (cm) begin
      m_arf[e_cdst] = e_cdata;
      if (m_loc[e_cdst] && m_map[e_cdst] == m_head && !(acc && dst == e_cdst)) begin
        m_loc[e_cdst] = 0; m_org[e_cdst] = "R11";
      end
      m_v[m_head] = 0; m_head = (m_head + 1) % 16; m_cnt--;
    end
    if (acc) begin
      m_loc[dst] = 1; m_map[dst] = m_tail; m_org[dst] = "R4";
      m_v[m_tail] = 1; m_r[m_tail] = 0; m_dst[m_tail] = dst;
      m_tail = (m_tail + 1) % 16; m_cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) m_arf[i] = '0;
    model_reset("R1");
    e_ov = 0; e_cv = 0; e_fl = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: every register reads committed zero
    step(1, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 2, 3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    // R7 forward, then R5 and R8 with commit of slot 0 (R10, R11)
    step(1, 1, 2, 3, 0, 0, 0, 0);
    step(1, 4, 1, 1, 1, 0, 32'hA5A5_0001, 0);
    step(1, 1, 1, 4, 0, 0, 0, 0);
    step(1, 5, 4, 1, 1, 1, 32'h0000_BEEF, 0);
    step(0, 0, 0, 0, 1, 2, 32'h1234_5678, 0);
    step(1, 6, 1, 4, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    // R12 flush, then R3 fill with a dropped request
    step(0, 0, 0, 0, 0, 0, 0, 1);
    for (int i = 0; i < 18; i++) step(1, i % 16, (i + 3) % 16, (i + 7) % 16, 0, 0, 0, 0);
    step(1, 2, 3, 4, 1, 0, 32'h0F0F_0F0F, 0);
    step(1, 2, 2, 0, 0, 0, 0, 0);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      bit iv, wv, fl;
      int wid;
      iv  = ($urandom % 100) < 70;
      wv  = ($urandom % 100) < 60;
      fl  = ($urandom % 100) < 2;
      wid = (($urandom % 4) == 0) ? int'($urandom % 16)
                                  : (m_head + int'($urandom % 16)) % 16;
      step(iv, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
           wv, wid, $urandom, fl);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_outputs();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule